// File: doc/BRIEF.md
# Windowed Watchdog and Reset Generator

This block supervises a microcontroller. Software has to prove that it is alive by issuing a clear strobe at regular intervals. Each strobe stands for a write to the timing register. Two supervision styles are available. In window mode, a clear that comes too early counts as a fault, just like a missing clear. In time-out mode, any clear that arrives before the period expires is accepted. All periods are counted in ticks of an external enable, normally one tick per millisecond.

The block has two active-low, registered outputs. The first is a reset line that goes to the processor. It is stretched to a fixed number of ticks after a watchdog fault. It is also held low for as long as the supply-good input is false, which covers both power-up and a supply drop. The second output is a fault flag. It falls together with the reset line and stays low until software issues a valid clear after the reset is over.

A valid clear also loads the mode bit and the period code from the configuration inputs. Changes on those inputs therefore never disturb a period that is already running.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst` is high, both `rst_n_o` and `wdog_n_o` are low. After `rst` the latched mode is window mode and the latched period code is 0, which gives 10 ticks.
- R2: The period codes give 0 = 10 ticks, 1 = 45 ticks, 2 = 100 ticks and 3 = 350 ticks. The code is latched from `cfg_per_i` only by a valid clear.
- R3: In window mode (`cfg_win_i` = 1 when latched), the closed window covers tick counts 0 up to (period>>1)-1. A clear in the closed window drives `rst_n_o` low on the next clock edge.
- R4: A valid clear restarts the period from count 0. A clear is valid in the open window of window mode, or at any count in time-out mode (`cfg_win_i` = 0 when latched).
- R5: If no valid clear arrives within the latched period, `rst_n_o` goes low after exactly that many ticks, counted from the start of the period.
- R6: After a watchdog fault, `rst_n_o` stays low for exactly RST_TICKS ticks (4 by default). The period then restarts from count 0.
- R7: `wdog_n_o` goes low in the same cycle as `rst_n_o`. It stays low after the reset is released, until the next valid clear.
- R8: While `supply_ok_i` is low, `rst_n_o` is held low. It rises one clock edge after `supply_ok_i` returns high.
- R9: A clear strobe that arrives while `rst_n_o` is low is ignored. It neither shortens the reset nor releases `wdog_n_o`.
- R10: A change on `cfg_win_i` or `cfg_per_i` without a valid clear has no effect on the running period or on the window rule.
- R11: The watchdog and reset counters advance only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base enable, one pulse per tick |
| clr_i | input | 1 | Clear strobe (timing-register write) |
| cfg_win_i | input | 1 | Mode loaded on clear: 1 = window, 0 = time-out |
| cfg_per_i | input | 2 | Period code loaded on clear |
| supply_ok_i | input | 1 | Supply within range |
| rst_n_o | output | 1 | Active-low processor reset |
| wdog_n_o | output | 1 | Active-low watchdog fault flag |

## Verification
The bench places clears on both sides of the closed/open boundary, at count half-1 and at count half, for the shortest and the longest period. A design that has an off-by-one error in the window split would reset on a legal clear, or would accept an early one. Period length and reset duration are measured in whole cycles, which exposes any counter that ends one tick early or late. Further cases are:
- configuration changes made without a clear, which a design that loads its settings continuously would pick up;
- clears issued during reset, which a leaky design would let release the fault flag;
- a supply drop in the middle of a period;
- a slowed tick, which shows whether counting is gated by the enable.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    WDT_MODE_TIMEOUT = 1'b0,
    WDT_MODE_WINDOW  = 1'b1
  } wdt_mode_e;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wdt_period_sel.sv
module wdt_period_sel #(
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned PER0_TICKS = 10,
  parameter int unsigned PER1_TICKS = 45,
  parameter int unsigned PER2_TICKS = 100,
  parameter int unsigned PER3_TICKS = 350
) (
  input  logic [1:0]       code_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] half_o
);

  localparam logic [CNT_W-1:0] TBL [4] = '{
    CNT_W'(PER0_TICKS), CNT_W'(PER1_TICKS),
    CNT_W'(PER2_TICKS), CNT_W'(PER3_TICKS)
  };

  always_comb begin
    period_o = TBL[code_i];
    half_o   = period_o >> 1;
  end

endmodule

// File: rtl/wdt_window_timer.sv
module wdt_window_timer
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             cfg_win_i,
  input  logic [1:0]       cfg_per_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] half_i,
  output logic [1:0]       code_o,
  output wdt_mode_e        mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             clr_ok_o,
  output logic             evt_o
);

  logic [CNT_W-1:0] cnt_q;
  wdt_mode_e        mode_q;
  logic [1:0]       code_q;
  logic             closed, clr_req, illegal, tout;

  always_comb begin
    closed   = (mode_q == WDT_MODE_WINDOW) && (cnt_q < half_i);
    clr_req  = clr_i && !hold_i;
    illegal  = clr_req && closed;
    clr_ok_o = clr_req && !closed;
    tout     = !hold_i && tick_i && (cnt_q == period_i - CNT_W'(1));
    evt_o    = illegal || (tout && !clr_ok_o);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= WDT_MODE_WINDOW;
      code_q <= 2'd0;
    end else if (hold_i) begin
      cnt_q <= '0;
    end else if (clr_ok_o) begin
      cnt_q  <= '0;
      mode_q <= wdt_mode_e'(cfg_win_i);
      code_q <= cfg_per_i;
    end else if (evt_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign code_o = code_q;
  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;

  // R6: the period restarts from zero while the reset line is held
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (cnt_q == '0));

  // R11: no tick, no advance (outside clears and faults)
  a_r11_tick_gate: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i && !hold_i) |=> $stable(cnt_q));

  // R10: latched settings only move on a clear
  a_r10_cfg_stable: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ($stable(code_q) && $stable(mode_q)));

endmodule

// File: rtl/wdt_reset_stretch.sv
module wdt_reset_stretch #(
  parameter int unsigned RST_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic evt_i,
  output logic active_o
);

  localparam int unsigned RW = $clog2(RST_TICKS + 1);

  logic [RW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (!supply_ok_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (evt_i) begin
      active_q <= 1'b1;
      cnt_q    <= RW'(RST_TICKS);
    end else if (active_q) begin
      if (cnt_q == '0) begin
        active_q <= 1'b0;
      end else if (tick_i) begin
        cnt_q <= cnt_q - RW'(1);
        if (cnt_q == RW'(1)) active_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;

  // R8: a bad supply forces the reset on the next edge
  a_r8_supply_hold: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> active_q);

  // R6: the stretch counter never exceeds its load value
  a_r6_len_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= RW'(RST_TICKS));

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int unsigned PER0_TICKS = 10,
  parameter int unsigned PER1_TICKS = 45,
  parameter int unsigned PER2_TICKS = 100,
  parameter int unsigned PER3_TICKS = 350,
  parameter int unsigned RST_TICKS  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       clr_i,
  input  logic       cfg_win_i,
  input  logic [1:0] cfg_per_i,
  input  logic       supply_ok_i,
  output logic       rst_n_o,
  output logic       wdog_n_o
);

  localparam int unsigned MAXP  = max4(PER0_TICKS, PER1_TICKS, PER2_TICKS, PER3_TICKS);
  localparam int unsigned CNT_W = $clog2(MAXP + 1);

  logic [CNT_W-1:0] period, half, cnt;
  logic [1:0]       code;
  wdt_mode_e        mode;
  logic             clr_ok, evt, active, fault_q;

  wdt_period_sel #(
    .CNT_W(CNT_W), .PER0_TICKS(PER0_TICKS), .PER1_TICKS(PER1_TICKS),
    .PER2_TICKS(PER2_TICKS), .PER3_TICKS(PER3_TICKS)
  ) u_per (
    .code_i(code), .period_o(period), .half_o(half)
  );

  wdt_window_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .tick_i(tick_i), .clr_i(clr_i), .hold_i(active),
    .cfg_win_i(cfg_win_i), .cfg_per_i(cfg_per_i),
    .period_i(period), .half_i(half),
    .code_o(code), .mode_o(mode), .cnt_o(cnt),
    .clr_ok_o(clr_ok), .evt_o(evt)
  );

  wdt_reset_stretch #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk(clk), .rst(rst), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
    .evt_i(evt), .active_o(active)
  );

  always_ff @(posedge clk) begin
    if (rst)                              fault_q <= 1'b1;
    else if (!supply_ok_i || evt || active) fault_q <= 1'b1;
    else if (clr_ok)                      fault_q <= 1'b0;
  end

  assign rst_n_o  = !active;
  assign wdog_n_o = !fault_q;

  // R7: fault flag is low whenever the reset line is low
  a_r7_flag_with_reset: assert property (@(posedge clk) disable iff (rst)
    !rst_n_o |-> !wdog_n_o);

  // R3: a clear in the closed window forces reset
  a_r3_closed_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && rst_n_o && mode == WDT_MODE_WINDOW && cnt < half) |=> !rst_n_o);

  // R5: expiry without a clear forces reset
  a_r5_expiry: assert property (@(posedge clk) disable iff (rst)
    (rst_n_o && tick_i && !clr_i && cnt == period - CNT_W'(1)) |=> !rst_n_o);

  // R9: the fault flag cannot be released while reset is low
  a_r9_no_release_in_reset: assert property (@(posedge clk) disable iff (rst)
    !rst_n_o |=> !wdog_n_o);

endmodule

// File: tb/wdt_supervisor_tb_top.sv
module wdt_supervisor_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b1;
  logic       clr_i = 1'b0;
  logic       cfg_win_i = 1'b1;
  logic [1:0] cfg_per_i = 2'd0;
  logic       supply_ok_i = 1'b1;
  logic       rst_n_o, wdog_n_o;
  logic       slow_tick = 1'b0;
  int         checks = 0;
  int         failures = 0;
  int         cyc = 0;

  always #2.5 clk = ~clk;

  wdt_supervisor dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .clr_i(clr_i),
    .cfg_win_i(cfg_win_i), .cfg_per_i(cfg_per_i), .supply_ok_i(supply_ok_i),
    .rst_n_o(rst_n_o), .wdog_n_o(wdog_n_o)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_i <= slow_tick ? (cyc % 2 == 0) : 1'b1;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; clr_i = 1'b0; cfg_win_i = 1'b1; cfg_per_i = 2'd0; supply_ok_i = 1'b1;
    wait_n(3);
    rst = 1'b0;
    for (int i = 0; i < 20 && !rst_n_o; i++) @(negedge clk);
  endtask

  task automatic pulse_clr(input bit win, input logic [1:0] code);
    cfg_win_i = win; cfg_per_i = code; clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic measure_high(output int n);
    n = 0;
    for (int i = 0; i < 2000 && rst_n_o; i++) begin n++; @(negedge clk); end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    for (int i = 0; i < 2000 && !rst_n_o; i++) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_defaults();
    int n;
    @(negedge clk); rst = 1'b1; wait_n(2);
    check(rst_n_o == 0, "R1 rst_n_o in reset", rst_n_o, 0);
    check(wdog_n_o == 0, "R1 wdog_n_o in reset", wdog_n_o, 0);
    rst = 1'b0; @(negedge clk);
    check(rst_n_o == 1, "R8 release with supply ok", rst_n_o, 1);
    check(wdog_n_o == 0, "R7 flag held after release", wdog_n_o, 0);
    measure_high(n);
    check(n == 10, "R1 R5 default period", n, 10);
    check(wdog_n_o == 0, "R7 flag low with reset", wdog_n_o, 0);
    measure_low(n);
    check(n == 4, "R6 reset duration", n, 4);
    measure_high(n);
    check(n == 10, "R6 period restarts after reset", n, 10);
  endtask

  task automatic t_closed_clear();
    int n;
    do_reset(); wait_n(4);
    pulse_clr(1'b1, 2'd0);
    check(rst_n_o == 0, "R3 clear at half-1 resets", rst_n_o, 0);
    measure_low(n);
    check(n == 4, "R6 duration after illegal clear", n, 4);
  endtask

  task automatic t_open_clear();
    int n;
    do_reset(); wait_n(5);
    pulse_clr(1'b1, 2'd0);
    check(rst_n_o == 1, "R4 clear at half accepted", rst_n_o, 1);
    check(wdog_n_o == 1, "R7 flag released by valid clear", wdog_n_o, 1);
    measure_high(n);
    check(n == 10, "R4 period restarted by clear", n, 10);
  endtask

  task automatic t_periods();
    int n;
    int exp_p [4] = '{10, 45, 100, 350};
    for (int c = 1; c < 4; c++) begin
      do_reset(); wait_n(5);
      pulse_clr(1'b1, 2'(c));
      measure_high(n);
      check(n == exp_p[c], $sformatf("R2 period code %0d", c), n, exp_p[c]);
    end
    do_reset(); wait_n(5); pulse_clr(1'b1, 2'd3);
    wait_n(174); pulse_clr(1'b1, 2'd3);
    check(rst_n_o == 0, "R3 code 3 clear at 174", rst_n_o, 0);
    do_reset(); wait_n(5); pulse_clr(1'b1, 2'd3);
    wait_n(175); pulse_clr(1'b1, 2'd3);
    check(rst_n_o == 1, "R4 code 3 clear at 175", rst_n_o, 1);
  endtask

  task automatic t_timeout_mode();
    int n;
    do_reset(); wait_n(5);
    pulse_clr(1'b0, 2'd0);
    pulse_clr(1'b0, 2'd0);
    check(rst_n_o == 1, "R4 time-out mode clear at count 0", rst_n_o, 1);
    wait_n(1); pulse_clr(1'b0, 2'd0);
    check(rst_n_o == 1, "R4 time-out mode clear at count 1", rst_n_o, 1);
    measure_high(n);
    check(n == 10, "R5 time-out mode expiry", n, 10);
  endtask

  task automatic t_cfg_no_effect();
    int n;
    do_reset();
    cfg_win_i = 1'b0; cfg_per_i = 2'd3;
    measure_high(n);
    check(n == 10, "R10 period unchanged without clear", n, 10);
    measure_low(n);
    wait_n(2); pulse_clr(1'b0, 2'd3);
    check(rst_n_o == 0, "R10 window rule unchanged without clear", rst_n_o, 0);
  endtask

  task automatic t_supply();
    do_reset(); wait_n(5); pulse_clr(1'b1, 2'd0);
    check(wdog_n_o == 1, "R7 flag high before drop", wdog_n_o, 1);
    supply_ok_i = 1'b0; @(negedge clk);
    check(rst_n_o == 0, "R8 reset on supply drop", rst_n_o, 0);
    check(wdog_n_o == 0, "R7 flag falls with supply reset", wdog_n_o, 0);
    wait_n(20);
    check(rst_n_o == 0, "R8 reset held while supply bad", rst_n_o, 0);
    supply_ok_i = 1'b1; @(negedge clk);
    check(rst_n_o == 1, "R8 release one edge after supply ok", rst_n_o, 1);
    check(wdog_n_o == 0, "R7 flag stays low after supply release", wdog_n_o, 0);
    wait_n(5); pulse_clr(1'b1, 2'd0);
    check(wdog_n_o == 1, "R7 flag released after valid clear", wdog_n_o, 1);
  endtask

  task automatic t_clear_in_reset();
    int n;
    do_reset();
    measure_high(n);
    pulse_clr(1'b1, 2'd0);
    check(wdog_n_o == 0, "R9 clear in reset leaves flag low", wdog_n_o, 0);
    measure_low(n);
    check(n == 3, "R9 clear in reset leaves duration", n, 3);
    check(wdog_n_o == 0, "R9 flag still low after release", wdog_n_o, 0);
    wait_n(5); pulse_clr(1'b1, 2'd0);
    check(rst_n_o == 1 && wdog_n_o == 1, "R6 restart at zero after reset", wdog_n_o, 1);
  endtask

  task automatic t_tick_gate();
    int n;
    slow_tick = 1'b1;
    do_reset();
    measure_high(n);
    check(n >= 19 && n <= 21, "R11 period counts ticks only", n, 20);
    slow_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset_defaults();
    t_closed_clear();
    t_open_clear();
    t_periods();
    t_timeout_mode();
    t_cfg_no_effect();
    t_supply();
    t_clear_in_reset();
    t_tick_gate();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule